// File: doc/BRIEF.md
# Three-Instruction Multi-Cycle 16-bit Core

This block is a small processor core that executes a three-instruction subset: a register-to-register add, an indirect jump through a register, and a load that adds a signed offset to a base register. It keeps a 16-bit program counter, an instruction register and eight 16-bit general registers. It steps each instruction through four phases, one clock each: fetch, decode, execute and write-back.

Code and data live in one word-addressed memory outside the block. Each address holds one 16-bit word. The core drives a read address and expects the addressed word on its data input one clock later. A start-address input sets where execution begins after reset. Debug outputs show the program counter and the current instruction, and a separate read port returns any general register.

Top module: `tri_op_core`

## Requirements
- R1: While rst_ni is low (asynchronous, active low), the PC equals start_addr_i, the instruction register reads 0x0000, all eight registers read zero, and the core is in the fetch phase.
- R2: Every instruction takes exactly four clocks. In the fetch clock, mem_addr_o equals the PC, and the PC is incremented by one at the end of that clock. The word returned is latched into the instruction register (dbg_ir_o) at the end of the following clock.
- R3: Opcode 0x1 in bits [15:12] adds two registers: destination in [11:9], first source in [8:6], second source in [2:0], and bits [5:3] are zero. The result is the sum modulo 2^16. Both sources are read before the destination is written, so a destination may also be a source.
- R4: Opcode 0x6 loads a word. The destination is in [11:9] and the base register in [8:6]. Bits [5:0] are a two's complement offset (-32..31), sign-extended and added to the base modulo 2^16. The destination receives the memory word at that address, and that word may be an instruction word.
- R5: Opcode 0xC, with the base register in [8:6], replaces the already-incremented PC with the base register's value. The next fetch uses that address.
- R6: Any opcode other than 0x1, 0x6 and 0xC changes no general register. The next fetch uses PC+1.
- R7: dbg_rdata_o combinationally returns the register selected by dbg_rsel_i, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_addr_i | input | 16 | PC value loaded during reset |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 16 | Memory word, valid one clock after its address |
| dbg_pc_o | output | 16 | Current program counter |
| dbg_ir_o | output | 16 | Current instruction register |
| dbg_rsel_i | input | 3 | Debug register select |
| dbg_rdata_o | output | 16 | Contents of the selected register |

## Verification
A fault in the phase sequencer or the PC update shows up on dbg_pc_o and mem_addr_o within one instruction: four clocks at most. From then on, every later fetch address is off. A wrong decode or write-back leaves a wrong value in a register that the debug port can read one instruction later. Because later loads and jumps use those registers as bases, the error then spreads into wrong addresses. Jumps and loads whose addresses are computed from earlier results therefore expose most single faults after a handful of instructions.

// File: rtl/tri_pkg.sv
package tri_pkg;
  localparam int XLEN    = 16;
  localparam int REG_CNT = 8;
  localparam int RIDX_W  = $clog2(REG_CNT);
  localparam int OFF_W   = 6;
  localparam int OPC_W   = 4;

  localparam logic [OPC_W-1:0] OPC_ADD = 4'h1;
  localparam logic [OPC_W-1:0] OPC_LDR = 4'h6;
  localparam logic [OPC_W-1:0] OPC_JMP = 4'hC;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_EXEC   = 2'd2,
    PH_WB     = 2'd3
  } phase_e;

  typedef struct packed {
    logic              is_add;
    logic              is_ldr;
    logic              is_jmp;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] sr1;
    logic [RIDX_W-1:0] sr2;
    logic [XLEN-1:0]   off;
  } dec_t;
endpackage

// File: rtl/tri_regfile.sv
module tri_regfile #(
  parameter int XLEN    = tri_pkg::XLEN,
  parameter int REG_CNT = tri_pkg::REG_CNT,
  localparam int RIDX_W = $clog2(REG_CNT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RIDX_W-1:0] waddr_i,
  input  logic [XLEN-1:0]   wdata_i,
  input  logic [RIDX_W-1:0] raddr_a_i,
  output logic [XLEN-1:0]   rdata_a_o,
  input  logic [RIDX_W-1:0] raddr_b_i,
  output logic [XLEN-1:0]   rdata_b_o,
  input  logic [RIDX_W-1:0] raddr_d_i,
  output logic [XLEN-1:0]   rdata_d_o
);
  logic [XLEN-1:0] regs_q [REG_CNT];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    regs_q[g] <= '0;
      else if (we_i && waddr_i == RIDX_W'(g))         regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
  assign rdata_d_o = regs_q[raddr_d_i];
endmodule

// File: rtl/tri_decode.sv
module tri_decode
  import tri_pkg::*;
(
  input  logic [XLEN-1:0] ir_i,
  output dec_t            dec_o
);
  logic [OPC_W-1:0] opc;

  assign opc = ir_i[XLEN-1 -: OPC_W];

  always_comb begin
    dec_o.is_add = (opc == OPC_ADD);
    dec_o.is_ldr = (opc == OPC_LDR);
    dec_o.is_jmp = (opc == OPC_JMP);
    dec_o.dst    = ir_i[11:9];
    dec_o.sr1    = ir_i[8:6];
    dec_o.sr2    = ir_i[2:0];
    dec_o.off    = {{(XLEN-OFF_W){ir_i[OFF_W-1]}}, ir_i[OFF_W-1:0]};
  end
endmodule

// File: rtl/tri_ctrl.sv
module tri_ctrl
  import tri_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    unique case (phase_q)
      PH_FETCH:  phase_d = PH_DECODE;
      PH_DECODE: phase_d = PH_EXEC;
      PH_EXEC:   phase_d = PH_WB;
      default:   phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_FETCH;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/tri_op_core.sv
module tri_op_core
  import tri_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] start_addr_i,
  output logic [15:0] mem_addr_o,
  input  logic [15:0] mem_rdata_i,
  output logic [15:0] dbg_pc_o,
  output logic [15:0] dbg_ir_o,
  input  logic [2:0]  dbg_rsel_i,
  output logic [15:0] dbg_rdata_o
);
  phase_e            phase;
  dec_t              dec;
  logic [XLEN-1:0]   pc_q, ir_q, tmp_q;
  logic [XLEN-1:0]   rd_a, rd_b, ldr_addr, wdata;
  logic              rf_we;

  tri_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase)
  );

  tri_decode u_dec (
    .ir_i  (ir_q),
    .dec_o (dec)
  );

  tri_regfile #(.XLEN(XLEN), .REG_CNT(REG_CNT)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (dec.dst),
    .wdata_i   (wdata),
    .raddr_a_i (dec.sr1),
    .rdata_a_o (rd_a),
    .raddr_b_i (dec.sr2),
    .rdata_b_o (rd_b),
    .raddr_d_i (dbg_rsel_i),
    .rdata_d_o (dbg_rdata_o)
  );

  assign ldr_addr = rd_a + dec.off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= start_addr_i;
      ir_q  <= '0;
      tmp_q <= '0;
    end else begin
      unique case (phase)
        PH_FETCH:  pc_q <= pc_q + 1'b1;
        PH_DECODE: ir_q <= mem_rdata_i;
        PH_EXEC: begin
          tmp_q <= rd_a + rd_b;
          if (dec.is_jmp) pc_q <= rd_a;
        end
        default: ;
      endcase
    end
  end

  // write-back: loads take the word fetched during execute
  assign rf_we      = (phase == PH_WB) && (dec.is_add || dec.is_ldr);
  assign wdata      = dec.is_ldr ? mem_rdata_i : tmp_q;
  assign mem_addr_o = (phase == PH_EXEC && dec.is_ldr) ? ldr_addr : pc_q;
  assign dbg_pc_o   = pc_q;
  assign dbg_ir_o   = ir_q;
endmodule

// File: rtl/tri_op_core_chk.sv
module tri_op_core_chk
  import tri_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input phase_e      phase_i,
  input logic [15:0] pc_i,
  input logic [15:0] ir_i,
  input logic [15:0] mem_addr_i,
  input logic [15:0] base_i,
  input logic        we_i
);
  logic [3:0]  opc;
  logic [15:0] sext;
  assign opc  = ir_i[15:12];
  assign sext = {{10{ir_i[5]}}, ir_i[5:0]};

  AST_PHASE_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == PH_FETCH |=> phase_i == PH_DECODE); // R2
  AST_FETCH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == PH_FETCH |-> mem_addr_i == pc_i); // R2
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == PH_FETCH |=> pc_i == $past(pc_i) + 16'd1); // R2
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_DECODE || phase_i == PH_WB) |=> $stable(pc_i)); // R2
  AST_IR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i != PH_DECODE |=> $stable(ir_i)); // R2
  AST_LDR_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_EXEC && opc == 4'h6) |-> mem_addr_i == base_i + sext); // R4
  AST_JMP_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_EXEC && opc == 4'hC) |=> pc_i == $past(base_i)); // R5
  AST_NOP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc != 4'h1 && opc != 4'h6) |-> !we_i); // R6
endmodule

bind tri_op_core tri_op_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .phase_i    (phase),
  .pc_i       (pc_q),
  .ir_i       (ir_q),
  .mem_addr_i (mem_addr_o),
  .base_i     (rd_a),
  .we_i       (rf_we)
);

// File: tb/tri_op_core_test.sv
`timescale 1ns/1ps
module tri_op_core_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] start_addr = 16'h3000;
  logic [15:0] mem_addr, mem_rdata, dbg_pc, dbg_ir, dbg_rdata;
  logic [2:0]  dbg_rsel = '0;
  int          tests = 0, fails = 0;
  logic [15:0] prog [64];

  always #10 clk = ~clk;

  tri_op_core uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_addr_i(start_addr),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .dbg_pc_o(dbg_pc), .dbg_ir_o(dbg_ir),
    .dbg_rsel_i(dbg_rsel), .dbg_rdata_o(dbg_rdata)
  );

  // program window 0x3000..0x303F; elsewhere word = address ^ 0x3000
  function automatic logic [15:0] mem_word(input logic [15:0] a);
    if (a[15:6] == 10'h0C0) return prog[a[5:0]];
    return a ^ 16'h3000;
  endfunction

  always @(posedge clk) mem_rdata <= mem_word(mem_addr);

  // {addr, instr, check reg, expected reg value, expected next pc}
  localparam logic [79:0] VEC [12] = '{
    {16'h3000, 16'h6205, 16'd1, 16'h3005, 16'h3001},
    {16'h3001, 16'h643F, 16'd2, 16'hCFFF, 16'h3002},
    {16'h3002, 16'h1642, 16'd3, 16'h0004, 16'h3003},
    {16'h3003, 16'h1241, 16'd1, 16'h600A, 16'h3004},
    {16'h3004, 16'h68FC, 16'd4, 16'h3000, 16'h3005},
    {16'h3005, 16'hF123, 16'd4, 16'h3000, 16'h3006},
    {16'h3006, 16'h6A20, 16'd5, 16'hCFE0, 16'h3007},
    {16'h3007, 16'h6CDC, 16'd6, 16'h3020, 16'h3008},
    {16'h3008, 16'hC180, 16'd6, 16'h3020, 16'h3020},
    {16'h3020, 16'h1F46, 16'd7, 16'h0000, 16'h3021},
    {16'h3021, 16'h6D81, 16'd6, 16'h6D81, 16'h3022},
    {16'h3022, 16'hC100, 16'd4, 16'h3000, 16'h3000}
  };

  localparam logic [15:0] FINAL_REGS [8] = '{
    16'h0000, 16'h600A, 16'hCFFF, 16'h0004,
    16'h3000, 16'hCFE0, 16'h6D81, 16'h0000
  };

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic read_reg(input int idx, output logic [15:0] val);
    dbg_rsel = 3'(idx);
    #1 val = dbg_rdata;
  endtask

  function automatic string tag_of(input logic [15:0] instr);
    case (instr[15:12])
      4'h1:    return "R3";
      4'h6:    return "R4";
      4'hC:    return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual 20000 cycles expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    for (int i = 0; i < 64; i++) prog[i] = 16'h0000;
    for (int i = 0; i < 12; i++)
      if (VEC[i][79:70] == 10'h0C0) prog[VEC[i][69:64]] = VEC[i][63:48];

    repeat (3) @(negedge clk);
    chk("R1", "pc in reset", dbg_pc, 16'h3000);
    chk("R1", "ir in reset", dbg_ir, 16'h0000);
    for (int r = 0; r < 8; r++) begin
      read_reg(r, v);
      chk("R1", "reg in reset", v, 16'h0000);
    end

    @(negedge clk);
    rst_ni = 1'b1;
    #1 chk("R2", "first fetch address", mem_addr, 16'h3000);

    for (int i = 0; i < 12; i++) begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R2", "ir after instruction", dbg_ir, VEC[i][63:48]);
      chk(tag_of(VEC[i][63:48]), "next pc", dbg_pc, VEC[i][15:0]);
      read_reg(int'(VEC[i][47:32]), v);
      chk(tag_of(VEC[i][63:48]), "dest reg", v, VEC[i][31:16]);
    end

    // R7: debug port sweep of final register state
    for (int r = 0; r < 8; r++) begin
      read_reg(r, v);
      chk("R7", "debug read", v, FINAL_REGS[r]);
    end

    // R1: asynchronous reset mid-instruction with a new start address
    repeat (2) @(posedge clk);
    @(negedge clk);
    start_addr = 16'h3010;
    rst_ni = 1'b0;
    #1 chk("R1", "pc async reset", dbg_pc, 16'h3010);
    read_reg(1, v);
    chk("R1", "reg1 cleared", v, 16'h0000);

    @(negedge clk);
    rst_ni = 1'b1;
    // R6: zero word is an unsupported opcode
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R6", "pc after nop", dbg_pc, 16'h3011);
    chk("R2", "fetch address follows pc", mem_addr, 16'h3011);
    chk("R6", "ir zero word", dbg_ir, 16'h0000);
    for (int r = 0; r < 8; r++) begin
      read_reg(r, v);
      chk("R6", "reg unchanged by nop", v, 16'h0000);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule